// File: doc/BRIEF.md
# Memory Type Range Resolver

The resolver turns one physical page address into an 8-bit cache memory type. Its decision draws on three groups of configuration: a control register that holds the fallback type and two enable bits, a table of 88 one-byte type entries that cover the lowest megabyte at three levels of detail, and `NUM_VAR` variable ranges. Each variable range is a base and mask register pair. Software or a boot sequencer loads all of these through a single write port that is addressed by a select number.

A lookup enters on a valid/ready request channel and leaves one cycle later on a valid/ready response channel. The resolver first checks the global enable. If that is set, the low-megabyte table is tried, provided the address lies in its window and the table is enabled. Otherwise every variable range is compared in parallel, and all the hits are folded into one type by a precedence rule. When nothing hits, the fallback type is returned.

The response stage is a two-state machine. `ST_EMPTY` holds no response, and `ST_FULL` holds one result. Three transitions are used:
- `ST_EMPTY` to `ST_FULL` when a request is accepted.
- `ST_FULL` to `ST_FULL` when the held result is consumed and a new request is accepted in the same cycle, or when the held result is not consumed.
- `ST_FULL` to `ST_EMPTY` when the result is consumed and no request arrives.

Top module: `memtype_resolver`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and every configuration register reads as zero. The global enable is therefore off after reset.
- R2: When bit 11 of the control register (the global enable) is 0, every response is 0xFF.
- R3: The low-megabyte table is indexed by address. Addresses below 0x80000 use entry addr>>16. Addresses from 0x80000 to 0xBFFFF use entry 8+((addr-0x80000)>>14). Addresses from 0xC0000 to 0xFFFFF use entry 24+((addr-0xC0000)>>12). Entry k is byte k%8, at bits 8*(k%8)+7 down to 8*(k%8), of table register k/8.
- R4: The table applies only when three conditions all hold: the address is below 0x100000, bit 10 of the control register is set, and `HAS_FIXED` is 1.
- R5: When the table applies, its entry is returned even if a variable range also matches.
- R6: A variable range takes part only if bit 11 of its mask register is set. It matches when (addr & mask) equals (base & mask) over bits `ADDR_W`-1 down to 12. Bits 11 down to 0 of the address, the base and the mask play no part in the compare. The range type is bits 7:0 of its base register.
- R7: Several matching ranges are merged as follows. If all the types are equal, that type is returned. Otherwise, if any type is uncacheable (0), the result is 0. Otherwise, if the only types are write-back (6) and write-through (4), the result is 4. Any other mix gives 0. Write-combining is 1 and write-protect is 5.
- R8: When the global enable is set and neither the table nor any variable range applies, the response is bits 7:0 of the control register.
- R9: A request accepted at a clock edge gives `rsp_valid` high after that edge, with a result that depends on the configuration as it stood before that edge. While `rsp_valid` is high and `rsp_ready` is low, the result stays stable and `req_ready` is low.
- R10: Writes use the following selects. Select 0 is the control register. Selects 1 to 11 are table registers 0 to 10. Select 16+2i is the base of range i, and select 17+2i is the mask of range i. A write to any other select changes no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | SEL_W | Configuration register select |
| wr_data | input | 64 | Configuration write value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_addr | input | ADDR_W | Physical address to resolve |
| rsp_valid | output | 1 | Resolved type available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_type | output | 8 | Resolved memory type or 0xFF |

## Verification
Directed addresses sit on each edge of the table's three regions, which separates the indexing of the three granularities. The address 0x100000 and a disabled table then show that the window and the enable both gate the table's priority over a range that covers it. Crafted overlaps pair write-back with write-through, write-combining with uncacheable, and equal types with each other, which separates the merge outcomes. Each overlap is then switched off one range at a time through its mask valid bit, until the fallback type appears. Random configurations mix aligned ranges of random size with random junk in the ignored low bits, and they are probed inside ranges, in the low megabyte and at random addresses. A held response under backpressure checks stability and the handoff to the next request.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
    typedef logic [7:0] mtype_t;

    localparam mtype_t MT_UC      = 8'h00;
    localparam mtype_t MT_WC      = 8'h01;
    localparam mtype_t MT_WT      = 8'h04;
    localparam mtype_t MT_WP      = 8'h05;
    localparam mtype_t MT_WB      = 8'h06;
    localparam mtype_t MT_INVALID = 8'hFF;

    localparam int PAGE_BITS    = 12;
    localparam int FIX_REGS     = 11;
    localparam int FIX_ENTRIES  = 88;
    localparam int VAR_SEL_BASE = 16;
    localparam int CTRL_GLOBAL  = 11;
    localparam int CTRL_FIXED   = 10;
    localparam int MASK_ON_BIT  = 11;

    typedef enum logic {ST_EMPTY, ST_FULL} rsp_state_e;

    // precedence rule for two overlapping range types
    function automatic mtype_t mt_merge(input mtype_t a, input mtype_t b);
        if (a == b)                      return a;
        if (a == MT_UC || b == MT_UC)    return MT_UC;
        if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB))
                                         return MT_WT;
        return MT_UC;
    endfunction
endpackage

// File: rtl/mtr_regfile.sv
module mtr_regfile
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int NUM_VAR = 8,
    parameter int SEL_W   = 5,
    localparam int PFN_W  = ADDR_W - PAGE_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [63:0]                  wr_data,
    output mtype_t                       def_type,
    output logic                         glob_en,
    output logic                         fix_en,
    output logic [FIX_REGS-1:0][63:0]    fix_q,
    output logic [NUM_VAR-1:0]           var_on,
    output logic [NUM_VAR-1:0][PFN_W-1:0] var_base,
    output logic [NUM_VAR-1:0][PFN_W-1:0] var_mask,
    output logic [NUM_VAR-1:0][7:0]      var_type
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            def_type <= MT_UC;
            glob_en  <= 1'b0;
            fix_en   <= 1'b0;
        end else if (wr_en && wr_sel == '0) begin
            def_type <= wr_data[7:0];
            glob_en  <= wr_data[CTRL_GLOBAL];
            fix_en   <= wr_data[CTRL_FIXED];
        end
    end

    for (genvar r = 0; r < FIX_REGS; r++) begin : g_fix
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                fix_q[r] <= '0;
            else if (wr_en && wr_sel == SEL_W'(r + 1))
                fix_q[r] <= wr_data;
        end
    end

    for (genvar i = 0; i < NUM_VAR; i++) begin : g_var
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                var_base[i] <= '0;
                var_type[i] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(VAR_SEL_BASE + 2*i)) begin
                var_base[i] <= wr_data[ADDR_W-1:PAGE_BITS];
                var_type[i] <= wr_data[7:0];
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                var_mask[i] <= '0;
                var_on[i]   <= 1'b0;
            end else if (wr_en && wr_sel == SEL_W'(VAR_SEL_BASE + 2*i + 1)) begin
                var_mask[i] <= wr_data[ADDR_W-1:PAGE_BITS];
                var_on[i]   <= wr_data[MASK_ON_BIT];
            end
        end
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> (def_type == $past(wr_data[7:0]))); // R10
endmodule

// File: rtl/mtr_fixed_lookup.sv
module mtr_fixed_lookup
    import mtr_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [FIX_REGS-1:0][63:0]  fix_q,
    output logic                       in_window,
    output mtype_t                     fix_type
);
    logic [6:0] entry;

    always_comb begin
        if (!addr[19])
            entry = {4'd0, addr[18:16]};
        else if (!addr[18])
            entry = 7'd8 + {3'd0, addr[17:14]};
        else
            entry = 7'd24 + {1'b0, addr[17:12]};
    end

    assign in_window = (addr[ADDR_W-1:20] == '0);
    assign fix_type  = fix_q[entry[6:3]][{entry[2:0], 3'b000} +: 8];
endmodule

// File: rtl/mtr_var_match.sv
module mtr_var_match
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int NUM_VAR = 8,
    localparam int PFN_W  = ADDR_W - PAGE_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PFN_W-1:0]              pfn,
    input  logic [NUM_VAR-1:0]            var_on,
    input  logic [NUM_VAR-1:0][PFN_W-1:0] var_base,
    input  logic [NUM_VAR-1:0][PFN_W-1:0] var_mask,
    input  logic [NUM_VAR-1:0][7:0]       var_type,
    output logic                          any_hit,
    output mtype_t                        merged
);
    logic [NUM_VAR-1:0] hit;
    logic [NUM_VAR-1:0] uc_hit;

    for (genvar i = 0; i < NUM_VAR; i++) begin : g_cmp
        assign hit[i]    = var_on[i] &&
                           ((pfn & var_mask[i]) == (var_base[i] & var_mask[i]));
        assign uc_hit[i] = hit[i] && (var_type[i] == MT_UC);
    end

    always_comb begin
        merged  = MT_UC;
        any_hit = 1'b0;
        for (int i = 0; i < NUM_VAR; i++) begin
            if (hit[i]) begin
                merged  = any_hit ? mt_merge(merged, var_type[i]) : var_type[i];
                any_hit = 1'b1;
            end
        end
    end

    AST_UC_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
        (|uc_hit) |-> (merged == MT_UC)); // R7
endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
    import mtr_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int NUM_VAR   = 8,
    parameter bit HAS_FIXED = 1'b1,
    localparam int SEL_W    = $clog2(VAR_SEL_BASE + 2*NUM_VAR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [63:0]       wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [7:0]        rsp_type
);
    localparam int PFN_W = ADDR_W - PAGE_BITS;

    mtype_t                         def_type;
    logic                           glob_en, fix_en;
    logic [FIX_REGS-1:0][63:0]      fix_q;
    logic [NUM_VAR-1:0]             var_on;
    logic [NUM_VAR-1:0][PFN_W-1:0]  var_base, var_mask;
    logic [NUM_VAR-1:0][7:0]        var_type;
    logic                           in_window, any_hit, accept;
    mtype_t                         fix_type, merged, resolved;
    rsp_state_e                     state_q, state_d;

    mtr_regfile #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .def_type(def_type), .glob_en(glob_en),
        .fix_en(fix_en), .fix_q(fix_q), .var_on(var_on),
        .var_base(var_base), .var_mask(var_mask), .var_type(var_type)
    );

    mtr_fixed_lookup #(.ADDR_W(ADDR_W)) u_fixed (
        .addr(req_addr), .fix_q(fix_q),
        .in_window(in_window), .fix_type(fix_type)
    );

    mtr_var_match #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_var (
        .clk(clk), .rst_n(rst_n), .pfn(req_addr[ADDR_W-1:PAGE_BITS]),
        .var_on(var_on), .var_base(var_base), .var_mask(var_mask),
        .var_type(var_type), .any_hit(any_hit), .merged(merged)
    );

    logic fixed_applies;
    assign fixed_applies = HAS_FIXED && fix_en && in_window;

    always_comb begin
        if (!glob_en)           resolved = MT_INVALID;
        else if (fixed_applies) resolved = fix_type;
        else if (any_hit)       resolved = merged;
        else                    resolved = def_type;
    end

    assign req_ready = (state_q == ST_EMPTY) || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign rsp_valid = (state_q == ST_FULL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept)                 state_d = ST_FULL;
            ST_FULL:  if (rsp_ready && !accept)   state_d = ST_EMPTY;
            default:                              state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_type <= MT_INVALID;
        else if (accept) rsp_type <= resolved;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_type))); // R9
    AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid); // R9
    AST_NO_READY_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready); // R9
    AST_DISABLED_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !glob_en) |=> (rsp_type == MT_INVALID)); // R2
    AST_FIXED_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && glob_en && fixed_applies) |=> (rsp_type == $past(fix_type))); // R5
endmodule

// File: tb/memtype_resolver_tb_top.sv
module memtype_resolver_tb_top;
    localparam int AW = 40;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_sel = '0;
    logic [63:0]   wr_data = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [7:0]    rsp_type;

    int tests = 0;
    int fails = 0;

    logic [63:0] m_ctrl;
    logic [63:0] m_fix  [11];
    logic [63:0] m_base [NV];
    logic [63:0] m_mask [NV];

    always #10 clk = ~clk;

    memtype_resolver #(.ADDR_W(AW), .NUM_VAR(NV), .HAS_FIXED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_type(rsp_type)
    );

    function automatic logic [7:0] combine(input logic [7:0] a, input logic [7:0] b);
        if (a == b) return a;
        if (a == 8'd0 || b == 8'd0) return 8'd0;
        if ((a == 8'd6 && b == 8'd4) || (a == 8'd4 && b == 8'd6)) return 8'd4;
        return 8'd0;
    endfunction

    function automatic logic [7:0] expect_type(input logic [AW-1:0] a);
        int idx;
        logic [AW-1:0] mk;
        logic [7:0] acc;
        bit found;
        if (!m_ctrl[11]) return 8'hFF;
        if (m_ctrl[10] && a < 40'h100000) begin
            if (a < 40'h80000)      idx = int'(a >> 16);
            else if (a < 40'hC0000) idx = 8 + int'((a - 40'h80000) >> 14);
            else                    idx = 24 + int'((a - 40'hC0000) >> 12);
            return 8'(m_fix[idx / 8] >> ((idx % 8) * 8));
        end
        found = 0;
        acc = 8'd0;
        for (int i = 0; i < NV; i++) begin
            mk = m_mask[i][AW-1:0] & ~40'hFFF;
            if (m_mask[i][11] && ((a & mk) == (m_base[i][AW-1:0] & mk))) begin
                acc = found ? combine(acc, m_base[i][7:0]) : m_base[i][7:0];
                found = 1;
            end
        end
        return found ? acc : m_ctrl[7:0];
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input int sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 0) m_ctrl = d;
        else if (sel >= 1 && sel <= 11) m_fix[sel-1] = d;
        else if (sel >= 16 && sel < 16 + 2*NV) begin
            if (sel % 2 == 0) m_base[(sel-16)/2] = d;
            else              m_mask[(sel-16)/2] = d;
        end
    endtask

    task automatic lookup(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid, 1, {tag, " rsp_valid"});
        check(rsp_type, expect_type(a), tag);
    endtask

    // range i with a 2^lg byte size at base b, type t, valid bit on
    task automatic set_range(input int i, input logic [AW-1:0] b, input int lg,
                             input logic [7:0] t, input bit on);
        logic [AW-1:0] mk;
        mk = ~((40'd1 << lg) - 40'd1);
        write_reg(16 + 2*i, {24'd0, b & mk} | {56'd0, t});
        write_reg(17 + 2*i, {24'd0, mk & ~40'hFFF} | (64'(on) << 11));
    endtask

    function automatic logic [7:0] rand_type();
        case ($urandom % 5)
            0: return 8'd0;
            1: return 8'd1;
            2: return 8'd4;
            3: return 8'd5;
            default: return 8'd6;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [AW-1:0] a, b;
        process::self().srandom(32'd1234);
        m_ctrl = '0;
        for (int r = 0; r < 11; r++) m_fix[r] = '0;
        for (int i = 0; i < NV; i++) begin m_base[i] = '0; m_mask[i] = '0; end

        repeat (3) @(negedge clk);
        check(rsp_valid, 0, "R1 reset rsp_valid");
        check(req_ready, 1, "R1 reset req_ready");
        rst_n = 1'b1;
        lookup(40'h12345000, "R1 reset config gives invalid");
        lookup(40'h00000000, "R2 global enable off");

        // table: entry k gets one of five types
        for (int r = 0; r < 11; r++) begin
            d = '0;
            for (int k = 0; k < 8; k++)
                d[k*8 +: 8] = 8'((r*8 + k) % 5 == 0 ? 0 : (r*8 + k) % 5 == 1 ? 1 :
                                 (r*8 + k) % 5 == 2 ? 4 : (r*8 + k) % 5 == 3 ? 5 : 6);
            d[7:0] = d[7:0] | 8'((r % 2) << 4);
            write_reg(r + 1, d);
        end
        write_reg(0, 64'hC05);
        lookup(40'h00000, "R3 entry 0");
        lookup(40'h7F000, "R3 entry 7");
        lookup(40'h80000, "R3 entry 8");
        lookup(40'hBF000, "R3 entry 23");
        lookup(40'hC0000, "R3 entry 24");
        lookup(40'hFF000, "R3 entry 87");
        lookup(40'hA4000, "R3 mid 16k region");

        set_range(0, 40'h0, 24, 8'd0, 1'b1);
        lookup(40'h05000, "R5 table beats covering range");
        lookup(40'h100000, "R4 first address past window");
        write_reg(0, 64'h805);
        lookup(40'h05000, "R4 table disabled");
        write_reg(0, 64'hC05);

        set_range(1, 40'h40000000, 20, 8'd6, 1'b1);
        set_range(2, 40'h40000000, 21, 8'd4, 1'b1);
        lookup(40'h40000000, "R7 wb with wt");
        lookup(40'h40100000, "R6 only larger range");
        set_range(3, 40'h40000000, 12, 8'd1, 1'b1);
        lookup(40'h40000000, "R7 mixed with wc");
        set_range(2, 40'h40000000, 21, 8'd4, 1'b0);
        lookup(40'h40080000, "R6 valid bit clear");
        set_range(1, 40'h40000000, 20, 8'd6, 1'b0);
        lookup(40'h40080000, "R8 default type");
        set_range(4, 40'h80000000, 12, 8'd1, 1'b1);
        set_range(5, 40'h80000000, 16, 8'd1, 1'b1);
        lookup(40'h80000000, "R7 equal types");
        set_range(6, 40'h80000000, 12, 8'd0, 1'b1);
        lookup(40'h80000000, "R7 uncacheable wins");

        write_reg(12, '1);
        write_reg(13, '1);
        write_reg(14, '1);
        lookup(40'h80000000, "R10 unmapped select");
        lookup(40'hC0000, "R10 unmapped select table");

        // backpressure
        @(negedge clk);
        rsp_ready = 1'b0; req_valid = 1'b1; a = 40'h40000000; req_addr = a;
        @(negedge clk);
        b = 40'hFF000; req_addr = b;
        check(rsp_valid, 1, "R9 held valid");
        check(rsp_type, expect_type(a), "R9 first result");
        check(req_ready, 0, "R9 ready low when held");
        repeat (2) @(negedge clk);
        check(rsp_type, expect_type(a), "R9 stable under backpressure");
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_type, expect_type(b), "R9 second result after handoff");
        @(negedge clk);
        check(rsp_valid, 0, "R9 drained");

        write_reg(0, 64'h406);
        lookup(40'h40000000, "R2 disabled after config");

        // random configurations
        for (int cfg = 0; cfg < 10; cfg++) begin
            d = {56'd0, rand_type()};
            if ($urandom % 5 != 0) d[11] = 1'b1;
            if ($urandom % 4 != 0) d[10] = 1'b1;
            write_reg(0, d);
            for (int r = 0; r < 11; r++) write_reg(r + 1, {$urandom, $urandom});
            for (int i = 0; i < NV; i++) begin
                int lg;
                logic [AW-1:0] mk, bs;
                lg = 12 + int'($urandom % 20);
                mk = ~((40'd1 << lg) - 40'd1);
                bs = {8'd0, $urandom % 4, 30'd0} | (40'($urandom) & mk);
                write_reg(16 + 2*i, {24'd0, bs & mk} | {52'd0, 4'($urandom), rand_type()});
                write_reg(17 + 2*i, {24'd0, mk & ~40'hFFF} |
                                    (64'($urandom % 4 != 0) << 11) | 64'($urandom % 2048));
            end
            for (int n = 0; n < 50; n++) begin
                int i;
                case ($urandom % 3)
                    0: a = 40'($urandom % 256) << 12;
                    1: begin
                        i = int'($urandom % NV);
                        a = (m_base[i][AW-1:0] & m_mask[i][AW-1:0]) |
                            ({$urandom, $urandom} & ~m_mask[i][AW-1:0]);
                        a = a & ~40'hFFF;
                    end
                    default: a = {$urandom, $urandom} & ~40'hFFF;
                endcase
                lookup(a, "R8 random lookup");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule